// File: doc/BRIEF.md
# Display Program Counter Control Decoder

This block sits between a main processor and a vector display processor. When the main processor executes an I/O-transfer instruction, the block decodes the 16-bit instruction word, read as six octal digits. The decode can load the display program counter from the accumulator, clear it, start or stop the display, clear the frame-sync flag, or ask the main processor to skip its next instruction when a 40 Hz frame-sync flag is set. While the display runs, the counter steps by one word for every fetch the display processor completes, because display words are read in sequence.

The instruction word is `instr_word[15:0]`, and bit 0 is its least significant bit. An instruction is in the I/O-transfer group when `instr_word[15:9]` equals octal 001. The device field is `instr_word[8:3]` and the operation bits are `instr_word[2:0]`. Device 00 controls the counter, device 01 controls the run state, and device 02 controls the sync flag. For the counter device, the load bit and the clear bit act independently. When both are set, the load takes precedence. This makes octal 001001 a working clear-counter instruction.

Top module: `disp_iot_ctl`

## Requirements
- R1: After reset, `dpc` is 0, `disp_run` is 0, `skip_req` is 0 and the sync flag is clear, so octal 001021 produces no skip.
- R2: Only words with `instr_word[15:9]` = octal 001 act. A word with any other value there (for example 000003, 003003 or 101003) leaves `dpc` unchanged.
- R3: When `exec_stb` is high and the word is octal 001002 (device 00, `instr_word[1]` set), `dpc` takes the value of `acc` on the next clock edge.
- R4: Octal 001001 (device 00, `instr_word[0]` set alone) sets `dpc` to 0 on the next edge.
- R5: Octal 001003 sets both bits. `dpc` takes `acc` and is not cleared.
- R6: A word in the group whose device field `instr_word[8:3]` is not zero (for example 001013, 001043, 001103 or 001403) has no effect on `dpc`. Octal 001000 has no effect on `dpc` either.
- R7: Octal 001011 sets `disp_run`. Octal 001012 clears it. Octal 001013 clears it, because stop wins over start.
- R8: While `disp_run` is 1, each `fetch_done` pulse adds 1 to `dpc`, and the count wraps from FFFF to 0. While `disp_run` is 0, `fetch_done` has no effect.
- R9: If a counter instruction executes in the same cycle as `fetch_done`, the instruction's result is stored and no increment happens.
- R10: A `sync_pulse` sets the sync flag. Octal 001024 clears it. If a pulse and the clear arrive in the same cycle, the flag stays set.
- R11: Octal 001021 with the sync flag set raises `skip_req` for exactly the one cycle after the strobe and leaves the flag set. With the flag clear, `skip_req` stays 0.
- R12: When `exec_stb` is low, the instruction word has no effect on any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_word | input | 16 | Instruction word from the main processor |
| exec_stb | input | 1 | One-cycle strobe; the instruction executes in this cycle |
| acc | input | 16 | Main processor accumulator |
| fetch_done | input | 1 | Display processor finished fetching one word |
| sync_pulse | input | 1 | 40 Hz frame-sync pulse |
| dpc | output | 16 | Display program counter |
| disp_run | output | 1 | Display processor run state |
| skip_req | output | 1 | One-cycle request to skip the next main-processor instruction |

## Verification
The hardest state to reach from the ports is the sync flag, because it is never an output. The bench makes it visible through the skip test. It sets the flag with a pulse and then probes it with 001021 twice in a row, which shows the flag survives a probe. It also drives the clear instruction in the same cycle as a sync pulse and probes again afterwards. A second collision case drives a counter instruction in the same cycle as a fetch while the display runs, so that precedence shows up as an exact `dpc` value.

// File: rtl/dpic_pkg.sv
package dpic_pkg;

   localparam int INSTR_W  = 16;
   localparam int GROUP_W  = 7;
   localparam int DEV_W    = 6;
   localparam int OP_W     = 3;

   // Decoded command set for one executed instruction.
   typedef struct packed {
      logic dpc_ld;
      logic dpc_clr;
      logic run_on;
      logic run_off;
      logic skip_sync;
      logic sync_clr;
   } iot_cmd_t;

endpackage

// File: rtl/iot_decode.sv
module iot_decode
   import dpic_pkg::*;
#(
   parameter logic [GROUP_W-1:0] GROUP_CODE = 7'o001,
   parameter logic [DEV_W-1:0]   DEV_DPC    = 6'o00,
   parameter logic [DEV_W-1:0]   DEV_RUN    = 6'o01,
   parameter logic [DEV_W-1:0]   DEV_SYNC   = 6'o02
) (
   input  logic [INSTR_W-1:0] instr_word,
   input  logic               exec_stb,
   output iot_cmd_t           cmd
);

   localparam int OP_LSB  = 0;
   localparam int DEV_LSB = OP_LSB + OP_W;
   localparam int GRP_LSB = DEV_LSB + DEV_W;

   generate
      if (GRP_LSB + GROUP_W != INSTR_W) begin : g_bad_fields
         $error("iot_decode: field widths must fill the instruction word");
      end
      if (DEV_DPC == DEV_RUN || DEV_DPC == DEV_SYNC || DEV_RUN == DEV_SYNC) begin : g_bad_dev
         $error("iot_decode: device codes must differ");
      end
   endgenerate

   logic [GROUP_W-1:0] grp;
   logic [DEV_W-1:0]   dev;
   logic [OP_W-1:0]    op;
   logic               in_group;
   logic               sel_dpc, sel_run, sel_sync;

   assign grp = instr_word[GRP_LSB +: GROUP_W];
   assign dev = instr_word[DEV_LSB +: DEV_W];
   assign op  = instr_word[OP_LSB +: OP_W];

   assign in_group = exec_stb && (grp == GROUP_CODE);
   assign sel_dpc  = in_group && (dev == DEV_DPC);
   assign sel_run  = in_group && (dev == DEV_RUN);
   assign sel_sync = in_group && (dev == DEV_SYNC);

   always_comb begin
      cmd           = '0;
      cmd.dpc_ld    = sel_dpc  && op[1];
      cmd.dpc_clr   = sel_dpc  && op[0];
      cmd.run_on    = sel_run  && op[0];
      cmd.run_off   = sel_run  && op[1];
      cmd.skip_sync = sel_sync && op[0];
      cmd.sync_clr  = sel_sync && op[2];
   end

endmodule

// File: rtl/dpc_reg.sv
module dpc_reg #(
   parameter int DPC_W           = 16,
   parameter bit LOAD_OVER_CLEAR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic             clr,
   input  logic             inc,
   input  logic [DPC_W-1:0] ld_val,
   output logic [DPC_W-1:0] dpc
);

   generate
      if (DPC_W < 1) begin : g_bad_w
         $error("dpc_reg: DPC_W must be positive");
      end
   endgenerate

   logic ld_eff, clr_eff;

   generate
      if (LOAD_OVER_CLEAR) begin : g_load_first
         assign ld_eff  = ld;
         assign clr_eff = clr && !ld;
      end else begin : g_clear_first
         assign ld_eff  = ld && !clr;
         assign clr_eff = clr;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       dpc <= '0;
      else if (ld_eff)  dpc <= ld_val;
      else if (clr_eff) dpc <= '0;
      else if (inc)     dpc <= dpc + 1'b1;
   end

   AST_LOAD_TAKES_ACC: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && (LOAD_OVER_CLEAR || !clr)) |=> dpc == $past(ld_val)); // R5
   AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !ld) |=> dpc == '0); // R4
   AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !ld && !clr) |=> dpc == $past(dpc) + 1'b1); // R8
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !ld && !clr) |=> $stable(dpc)); // R6

endmodule

// File: rtl/run_sync_ctl.sv
module run_sync_ctl
   import dpic_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  iot_cmd_t cmd,
   input  logic     sync_pulse,
   output logic     disp_run,
   output logic     skip_req
);

   logic sync_flag;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         disp_run  <= 1'b0;
         sync_flag <= 1'b0;
         skip_req  <= 1'b0;
      end else begin
         if (cmd.run_off)     disp_run <= 1'b0;
         else if (cmd.run_on) disp_run <= 1'b1;
         if (sync_pulse)        sync_flag <= 1'b1;
         else if (cmd.sync_clr) sync_flag <= 1'b0;
         skip_req <= cmd.skip_sync && sync_flag;
      end
   end

   AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.run_off |=> !disp_run); // R7
   AST_SYNC_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
      sync_pulse |=> sync_flag); // R10
   AST_SKIP_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      skip_req |-> $past(sync_flag)); // R11

endmodule

// File: rtl/disp_iot_ctl.sv
module disp_iot_ctl
   import dpic_pkg::*;
#(
   parameter int DATA_W          = 16,
   parameter int DPC_W           = 16,
   parameter bit LOAD_OVER_CLEAR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       instr_word,
   input  logic              exec_stb,
   input  logic [DATA_W-1:0] acc,
   input  logic              fetch_done,
   input  logic              sync_pulse,
   output logic [DPC_W-1:0]  dpc,
   output logic              disp_run,
   output logic              skip_req
);

   generate
      if (DPC_W > DATA_W) begin : g_bad_dpc
         $error("disp_iot_ctl: DPC_W may not exceed DATA_W");
      end
   endgenerate

   iot_cmd_t cmd;

   iot_decode u_decode (
      .instr_word (instr_word),
      .exec_stb   (exec_stb),
      .cmd        (cmd)
   );

   dpc_reg #(
      .DPC_W           (DPC_W),
      .LOAD_OVER_CLEAR (LOAD_OVER_CLEAR)
   ) u_dpc (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (cmd.dpc_ld),
      .clr    (cmd.dpc_clr),
      .inc    (fetch_done && disp_run),
      .ld_val (acc[DPC_W-1:0]),
      .dpc    (dpc)
   );

   run_sync_ctl u_run (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd        (cmd),
      .sync_pulse (sync_pulse),
      .disp_run   (disp_run),
      .skip_req   (skip_req)
   );

   AST_QUIET_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (!exec_stb && !fetch_done) |=> $stable(dpc)); // R12
   AST_STOPPED_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!exec_stb && !disp_run) |=> $stable(dpc)); // R8

endmodule

// File: tb/test_disp_iot_ctl.sv
module test_disp_iot_ctl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] instr_word = '0;
   logic        exec_stb = 1'b0;
   logic [15:0] acc = '0;
   logic        fetch_done = 1'b0;
   logic        sync_pulse = 1'b0;
   logic [15:0] dpc;
   logic        disp_run;
   logic        skip_req;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   disp_iot_ctl i_disp_iot_ctl (
      .clk (clk), .rst_n (rst_n), .instr_word (instr_word), .exec_stb (exec_stb),
      .acc (acc), .fetch_done (fetch_done), .sync_pulse (sync_pulse),
      .dpc (dpc), .disp_run (disp_run), .skip_req (skip_req)
   );

   localparam logic [15:0] PRE = 16'h5A5A;
   localparam int NV = 12;
   // {instruction, accumulator, expected dpc}, each walked from dpc = PRE
   localparam logic [47:0] VEC [NV] = '{
      {16'o001000, 16'h1111, PRE},      // R6 no op bits
      {16'o001001, 16'h2222, 16'h0000}, // R4 clear
      {16'o001002, 16'hBEEF, 16'hBEEF}, // R3 load
      {16'o001003, 16'hC0DE, 16'hC0DE}, // R5 load wins
      {16'o001013, 16'h3333, PRE},      // R6 device 01
      {16'o001043, 16'h4444, PRE},      // R6
      {16'o001103, 16'h5555, PRE},      // R6
      {16'o001403, 16'h6666, PRE},      // R6
      {16'o000003, 16'h7777, PRE},      // R2
      {16'o003003, 16'h8888, PRE},      // R2
      {16'o101003, 16'h9999, PRE},      // R2
      {16'o001002, 16'h0000, 16'h0000}  // R3 load of zero
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic iot(input logic [15:0] w, input logic [15:0] a);
      @(negedge clk);
      instr_word = w; acc = a; exec_stb = 1'b1;
      @(negedge clk);
      exec_stb = 1'b0; instr_word = '0;
   endtask

   task automatic fetch();
      @(negedge clk); fetch_done = 1'b1;
      @(negedge clk); fetch_done = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 dpc", dpc, 0);
      chk("R1 run", disp_run, 0);
      chk("R1 skip", skip_req, 0);
      rst_n = 1'b1;
      iot(16'o001021, 0);
      chk("R1 sync flag clear", skip_req, 0);

      for (int i = 0; i < NV; i++) begin
         iot(16'o001002, PRE);
         iot(VEC[i][47:32], VEC[i][31:16]);
         chk($sformatf("R2/R3/R4/R5/R6 vec%0d", i), dpc, VEC[i][15:0]);
      end

      // R12: word present without strobe
      iot(16'o001002, 16'h0123);
      @(negedge clk); instr_word = 16'o001001; acc = 16'hFFFF;
      @(negedge clk); instr_word = '0;
      chk("R12 no strobe", dpc, 16'h0123);

      // R8 stopped: no step
      fetch();
      chk("R8 stopped fetch", dpc, 16'h0123);
      // R7 start
      iot(16'o001011, 0);
      chk("R7 start", disp_run, 1);
      for (int k = 0; k < 3; k++) fetch();
      chk("R8 three fetches", dpc, 16'h0126);
      iot(16'o001002, 16'hFFFF);
      fetch();
      chk("R8 wrap", dpc, 16'h0000);
      // R9 collision with load and clear
      @(negedge clk);
      instr_word = 16'o001002; acc = 16'h4000; exec_stb = 1'b1; fetch_done = 1'b1;
      @(negedge clk);
      exec_stb = 1'b0; fetch_done = 1'b0; instr_word = '0;
      chk("R9 load beats fetch", dpc, 16'h4000);
      @(negedge clk);
      instr_word = 16'o001001; exec_stb = 1'b1; fetch_done = 1'b1;
      @(negedge clk);
      exec_stb = 1'b0; fetch_done = 1'b0; instr_word = '0;
      chk("R9 clear beats fetch", dpc, 16'h0000);
      // R7 stop, then both bits
      iot(16'o001012, 0);
      chk("R7 stop", disp_run, 0);
      fetch();
      chk("R8 fetch after stop", dpc, 16'h0000);
      iot(16'o001011, 0);
      iot(16'o001013, 0);
      chk("R7 stop wins", disp_run, 0);

      // R10/R11 sync flag and skip
      @(negedge clk); sync_pulse = 1'b1;
      @(negedge clk); sync_pulse = 1'b0;
      iot(16'o001021, 0);
      chk("R11 skip raised", skip_req, 1);
      @(negedge clk);
      chk("R11 skip one cycle", skip_req, 0);
      iot(16'o001021, 0);
      chk("R11 flag kept", skip_req, 1);
      iot(16'o001024, 0);
      iot(16'o001021, 0);
      chk("R10 flag cleared", skip_req, 0);
      @(negedge clk);
      instr_word = 16'o001024; exec_stb = 1'b1; sync_pulse = 1'b1;
      @(negedge clk);
      exec_stb = 1'b0; sync_pulse = 1'b0; instr_word = '0;
      iot(16'o001021, 0);
      chk("R10 pulse beats clear", skip_req, 1);

      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule